// File: doc/BRIEF.md
# Interrupt Distributor Front Control Registers

This block sits at the head of an interrupt distributor and holds the small set of words that govern it as a whole. It keeps one global enable bit. It reports a read-only capability word that is derived from the build parameters: the number of shared interrupts plus the 32 private ones, and the number of processors. It also returns a fixed identity word that carries a product code, a revision number and an implementer code.

When the enable bit goes from off to on, the block drives a registered wake pulse to every processor for exactly one clock. Processors that were waiting on a disabled distributor use this pulse to re-examine their pending work.

Two write sources reach the block. The main 32-bit register port reads and writes the words, with the word selected by address bits [3:2]. A separate configuration port writes the same words for save and restore. On that port, an identity write whose value differs from the built-in identity is refused and flagged.

Top module: `intc_front_regs`

## Requirements
- R1: After reset the enable bit is 0, the wake vector is all zeros and the error flag is 0.
- R2: An aligned read at offset 0x0 returns the enable bit in bit 0 and zeros in every other bit. A full-strobe aligned write there loads bit 0 into the enable and discards the other bits.
- R3: An aligned read at offset 0x4 returns the capability word. Bits [4:0] hold ((NUM_SPI + 32) / 32) - 1, bits [7:5] hold NUM_CPU - 1, and the remaining bits are zero.
- R4: An aligned read at offset 0x8 returns the identity word: PRODUCT_ID in [31:24], REVISION in [15:12], IMPL_CODE in [11:0], zeros elsewhere. Main-port writes to it change nothing.
- R5: A write that takes the enable from 0 to 1 sets every bit of `kick_o` in the cycle after the write edge, for exactly one cycle.
- R6: A write of 1 while already enabled, or any write of 0, leaves `kick_o` at zero.
- R7: A configuration write to offset 0x8 whose data differs from the identity word raises `cfg_err_o` for one cycle, in the cycle after the write edge. A matching value raises no error and changes no state.
- R8: A configuration write to offset 0x0 updates the enable exactly as a main-port write does, including the wake pulse. A configuration write to offset 0x4 has no effect.
- R9: Main-port writes to offset 0x4 have no effect. Offset 0xC reads as zero. `bus_rdata` is zero whenever no aligned read is presented.
- R10: An access with address bits [1:0] non-zero is ignored and reads zero. A main-port write with `bus_be` other than 4'hF is ignored.
- R11: `grp_cfg_o` is 1 when REVISION is 2 or more, meaning interrupt groups follow their configuration. It is 0 for revision 1, where every interrupt is reported as group 0.
- R12: When both ports write offset 0x0 in the same cycle, the main-port value is the one that takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Main port access strobe |
| bus_we | input | 1 | Main port write (1) or read (0) |
| bus_addr | input | ADDR_W | Main port byte address |
| bus_wdata | input | 32 | Main port write data |
| bus_be | input | 4 | Main port byte strobes |
| bus_rdata | output | 32 | Main port read data, combinational |
| cfg_req | input | 1 | Configuration port write strobe |
| cfg_addr | input | ADDR_W | Configuration port byte address |
| cfg_wdata | input | 32 | Configuration port write data |
| cfg_err_o | output | 1 | Identity mismatch flag, one cycle |
| kick_o | output | NUM_CPU | Per-processor wake pulse |
| grp_cfg_o | output | 1 | Interrupt groups are configurable |

## Verification
The assertions assume that `bus_addr` and `cfg_addr` are stable and defined whenever their request strobes are high. They also assume that a main-port access and its read data are evaluated in the same cycle, with no outstanding transaction. The bench changes every input only at the falling edge and holds it for one full cycle. It drives only defined values, so each request is seen at exactly one rising edge. Simultaneous writes from both ports are issued on purpose, so that the priority rule is checked inside that same contract.

// File: rtl/intc_front_pkg.sv
package intc_front_pkg;

    typedef enum logic [1:0] {
        SLOT_CTRL  = 2'd0,
        SLOT_CAPS  = 2'd1,
        SLOT_IDENT = 2'd2,
        SLOT_NONE  = 2'd3
    } slot_e;

    localparam int unsigned PRIV_IRQS = 32;

    function automatic logic [31:0] make_caps_word(int unsigned nspi, int unsigned ncpu);
        logic [31:0] w;
        w      = '0;
        w[4:0] = 5'((nspi + PRIV_IRQS) / 32 - 1);
        w[7:5] = 3'(ncpu - 1);
        return w;
    endfunction

    function automatic logic [31:0] make_ident_word(logic [7:0] prod, logic [3:0] rev,
                                                    logic [11:0] impl);
        logic [31:0] w;
        w        = '0;
        w[31:24] = prod;
        w[15:12] = rev;
        w[11:0]  = impl;
        return w;
    endfunction

endpackage

// File: rtl/intc_front_decode.sv
module intc_front_decode
    import intc_front_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        strobe,
    output logic              rd_ok,
    output logic              wr_ok,
    output slot_e             slot
);

    logic aligned;
    logic in_win;

    assign aligned = (addr[1:0] == 2'b00);

    generate
        if (ADDR_W > 4) begin : g_upper
            assign in_win = (addr[ADDR_W-1:4] == '0);
        end else begin : g_flat
            assign in_win = 1'b1;
        end
    endgenerate

    assign slot  = slot_e'(addr[3:2]);
    assign rd_ok = req && !we && aligned && in_win;
    assign wr_ok = req && we && aligned && in_win && (strobe == 4'hF);

endmodule

// File: rtl/intc_front_words.sv
module intc_front_words
    import intc_front_pkg::*;
#(
    parameter int          NUM_SPI    = 64,
    parameter int          NUM_CPU    = 4,
    parameter int          REVISION   = 2,
    parameter logic [7:0]  PRODUCT_ID = 8'h4B,
    parameter logic [11:0] IMPL_CODE  = 12'h43B
) (
    input  logic        rd_en,
    input  slot_e       slot,
    input  logic        enable,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] rdata,
    output logic        ident_match,
    output logic        grp_cfg
);

    localparam logic [31:0] CAPS_WORD  = make_caps_word(NUM_SPI, NUM_CPU);
    localparam logic [31:0] IDENT_WORD = make_ident_word(PRODUCT_ID, 4'(REVISION), IMPL_CODE);
    localparam logic        GRP_CFG    = (REVISION >= 2);

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (slot)
                SLOT_CTRL:  rdata = {31'b0, enable};
                SLOT_CAPS:  rdata = CAPS_WORD;
                SLOT_IDENT: rdata = IDENT_WORD;
                default:    rdata = '0;
            endcase
        end
    end

    assign ident_match = (cfg_wdata == IDENT_WORD);
    assign grp_cfg     = GRP_CFG;

endmodule

// File: rtl/intc_front_ctrl.sv
module intc_front_ctrl #(
    parameter int NUM_CPU = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr_ctrl,
    input  logic               bus_wbit,
    input  logic               cfg_wr_ctrl,
    input  logic               cfg_wbit,
    input  logic               cfg_wr_ident,
    input  logic               ident_match,
    output logic               en_o,
    output logic [NUM_CPU-1:0] kick_o,
    output logic               err_o
);

    typedef struct packed {
        logic               en;
        logic [NUM_CPU-1:0] kick;
        logic               err;
    } ctrl_st_t;

    ctrl_st_t st_d;
    ctrl_st_t st_q;

    always_comb begin
        st_d      = st_q;
        st_d.kick = '0;
        st_d.err  = 1'b0;
        if (bus_wr_ctrl) begin
            st_d.en = bus_wbit;
        end else if (cfg_wr_ctrl) begin
            st_d.en = cfg_wbit;
        end
        if (!st_q.en && st_d.en) begin
            st_d.kick = '1;
        end
        if (cfg_wr_ident && !ident_match) begin
            st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o   = st_q.en;
    assign kick_o = st_q.kick;
    assign err_o  = st_q.err;

endmodule

// File: rtl/intc_front_regs.sv
module intc_front_regs
    import intc_front_pkg::*;
#(
    parameter int          ADDR_W     = 4,
    parameter int          NUM_SPI    = 64,
    parameter int          NUM_CPU    = 4,
    parameter int          REVISION   = 2,
    parameter logic [7:0]  PRODUCT_ID = 8'h4B,
    parameter logic [11:0] IMPL_CODE  = 12'h43B
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_req,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic [3:0]         bus_be,
    output logic [31:0]        bus_rdata,
    input  logic               cfg_req,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [31:0]        cfg_wdata,
    output logic               cfg_err_o,
    output logic [NUM_CPU-1:0] kick_o,
    output logic               grp_cfg_o
);

    logic  bus_rd_ok, bus_wr_ok;
    logic  cfg_rd_ok, cfg_wr_ok;
    slot_e bus_slot, cfg_slot;
    logic  enable_w;
    logic  ident_match;

    intc_front_decode #(.ADDR_W(ADDR_W)) u_bus_dec (
        .req    (bus_req),
        .we     (bus_we),
        .addr   (bus_addr),
        .strobe (bus_be),
        .rd_ok  (bus_rd_ok),
        .wr_ok  (bus_wr_ok),
        .slot   (bus_slot)
    );

    intc_front_decode #(.ADDR_W(ADDR_W)) u_cfg_dec (
        .req    (cfg_req),
        .we     (1'b1),
        .addr   (cfg_addr),
        .strobe (4'hF),
        .rd_ok  (cfg_rd_ok),
        .wr_ok  (cfg_wr_ok),
        .slot   (cfg_slot)
    );

    intc_front_words #(
        .NUM_SPI    (NUM_SPI),
        .NUM_CPU    (NUM_CPU),
        .REVISION   (REVISION),
        .PRODUCT_ID (PRODUCT_ID),
        .IMPL_CODE  (IMPL_CODE)
    ) u_words (
        .rd_en       (bus_rd_ok),
        .slot        (bus_slot),
        .enable      (enable_w),
        .cfg_wdata   (cfg_wdata),
        .rdata       (bus_rdata),
        .ident_match (ident_match),
        .grp_cfg     (grp_cfg_o)
    );

    intc_front_ctrl #(.NUM_CPU(NUM_CPU)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr_ctrl  (bus_wr_ok && (bus_slot == SLOT_CTRL)),
        .bus_wbit     (bus_wdata[0]),
        .cfg_wr_ctrl  (cfg_wr_ok && (cfg_slot == SLOT_CTRL)),
        .cfg_wbit     (cfg_wdata[0]),
        .cfg_wr_ident (cfg_wr_ok && (cfg_slot == SLOT_IDENT) && !cfg_rd_ok),
        .ident_match  (ident_match),
        .en_o         (enable_w),
        .kick_o       (kick_o),
        .err_o        (cfg_err_o)
    );

endmodule

// File: rtl/intc_front_regs_chk.sv
module intc_front_regs_chk #(
    parameter int ADDR_W  = 4,
    parameter int NUM_CPU = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_req,
    input logic               bus_we,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_rdata,
    input logic               cfg_req,
    input logic [ADDR_W-1:0]  cfg_addr,
    input logic               cfg_err_o,
    input logic [NUM_CPU-1:0] kick_o,
    input logic               enable_w
);

    // R5
    kick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_o != '0) |=> (kick_o == '0));

    // R5
    kick_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_o != '0) |-> ($countones(kick_o) == NUM_CPU));

    // R5
    kick_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_o != '0) |-> (enable_w && !$past(enable_w)));

    // R6
    no_kick_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_w && $past(enable_w)) |-> (kick_o == '0));

    // R7
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> $past(cfg_req && (cfg_addr == ADDR_W'(8))));

    // R2
    ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && (bus_addr == '0)) |-> (bus_rdata == {31'b0, enable_w}));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && (bus_addr == ADDR_W'(12))) |-> (bus_rdata == '0));

    // R10
    misalign_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && (bus_addr[1:0] != 2'b00)) |-> (bus_rdata == '0));

endmodule

bind intc_front_regs intc_front_regs_chk #(.ADDR_W(ADDR_W), .NUM_CPU(NUM_CPU)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .cfg_req   (cfg_req),
    .cfg_addr  (cfg_addr),
    .cfg_err_o (cfg_err_o),
    .kick_o    (kick_o),
    .enable_w  (enable_w)
);

// File: tb/intc_front_regs_tb.sv
`timescale 1ns/100ps
module intc_front_regs_tb;

    localparam int NSPI = 64;
    localparam int NCPU = 4;
    localparam int REV  = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_req = 0, bus_we = 0;
    logic [3:0]      bus_addr = 0;
    logic [31:0]     bus_wdata = 0;
    logic [3:0]      bus_be = 0;
    logic [31:0]     bus_rdata;
    logic            cfg_req = 0;
    logic [3:0]      cfg_addr = 0;
    logic [31:0]     cfg_wdata = 0;
    logic            cfg_err_o;
    logic [NCPU-1:0] kick_o;
    logic            grp_cfg_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    int m_en = 0;
    int m_kick = 0;
    int m_err = 0;

    // expected words from the requirement text
    int exp_caps  = ((NSPI + 32) / 32 - 1) + ((NCPU - 1) * 32);
    int exp_ident = 'h4B * (1 << 24) + REV * (1 << 12) + 'h43B;

    always #2.5 clk = ~clk;

    intc_front_regs #(.NUM_SPI(NSPI), .NUM_CPU(NCPU), .REVISION(REV)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
        .cfg_req(cfg_req), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_err_o(cfg_err_o), .kick_o(kick_o), .grp_cfg_o(grp_cfg_o)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int model_read(bit req, bit we, int addr);
        if (!req || we || (addr % 4) != 0) return 0;
        case (addr)
            0: return m_en;
            4: return exp_caps;
            8: return exp_ident;
            default: return 0;
        endcase
    endfunction

    // one cycle: drive at falling edge, check read, model the edge, check registered outputs
    task automatic step(input string tag, input bit breq, input bit bwe, input int baddr,
                        input int bwd, input int bbe, input bit creq, input int caddr,
                        input int cwd);
        int nen;
        bus_req = breq; bus_we = bwe; bus_addr = 4'(baddr);
        bus_wdata = 32'(bwd); bus_be = 4'(bbe);
        cfg_req = creq; cfg_addr = 4'(caddr); cfg_wdata = 32'(cwd);
        #1;
        check(tag, bus_rdata, 32'(model_read(breq, bwe, baddr)));
        @(posedge clk);
        nen = m_en;
        if (breq && bwe && baddr == 0 && bbe == 'hF) nen = bwd & 1;
        else if (creq && caddr == 0) nen = cwd & 1;
        m_kick = (m_en == 0 && nen == 1) ? ((1 << NCPU) - 1) : 0;
        m_err  = (creq && caddr == 8 && cwd != exp_ident) ? 1 : 0;
        m_en   = nen;
        @(negedge clk);
        check(m_kick != 0 ? "R5" : "R6", kick_o, m_kick);
        check("R7", cfg_err_o, m_err);
        check("R11", grp_cfg_o, (REV >= 2) ? 1 : 0);
    endtask

    initial begin
        #(5.0 * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", kick_o, 0);
        check("R1", cfg_err_o, 0);
        step("R1", 1, 0, 0, 0, 0, 0, 0, 0);
        // R3 R4 R9 R10 reads
        step("R3", 1, 0, 4, 0, 0, 0, 0, 0);
        step("R4", 1, 0, 8, 0, 0, 0, 0, 0);
        step("R9", 1, 0, 12, 0, 0, 0, 0, 0);
        step("R10", 1, 0, 5, 0, 0, 0, 0, 0);
        step("R9", 0, 0, 4, 0, 0, 0, 0, 0);
        // R9 type write ignored
        step("R9", 1, 1, 4, 'hFFFF, 'hF, 0, 0, 0);
        step("R9", 1, 0, 4, 0, 0, 0, 0, 0);
        // R4 ident write ignored
        step("R4", 1, 1, 8, 0, 'hF, 0, 0, 0);
        step("R4", 1, 0, 8, 0, 0, 0, 0, 0);
        // R10 partial strobe and misaligned writes
        step("R10", 1, 1, 0, 1, 'h3, 0, 0, 0);
        step("R10", 1, 1, 1, 1, 'hF, 0, 0, 0);
        step("R10", 1, 0, 0, 0, 0, 0, 0, 0);
        // R2 upper bits discarded
        step("R2", 1, 1, 0, 'hFFFFFFFE, 'hF, 0, 0, 0);
        step("R2", 1, 0, 0, 0, 0, 0, 0, 0);
        // R5 enable
        step("R5", 1, 1, 0, 'h3, 'hF, 0, 0, 0);
        step("R2", 1, 0, 0, 0, 0, 0, 0, 0);
        // R6 write 1 again, then 0
        step("R6", 1, 1, 0, 1, 'hF, 0, 0, 0);
        step("R6", 1, 1, 0, 0, 'hF, 0, 0, 0);
        step("R2", 1, 0, 0, 0, 0, 0, 0, 0);
        // R8 configuration control write
        step("R8", 0, 0, 0, 0, 0, 1, 0, 1);
        step("R8", 1, 0, 0, 0, 0, 0, 0, 0);
        step("R8", 0, 0, 0, 0, 0, 1, 4, 'h1234);
        step("R8", 1, 0, 4, 0, 0, 0, 0, 0);
        // R7 identity compare
        step("R7", 0, 0, 0, 0, 0, 1, 8, 'h1);
        step("R7", 0, 0, 0, 0, 0, 1, 8, exp_ident);
        step("R7", 0, 0, 0, 0, 0, 1, 8, exp_ident ^ 'h1000);
        step("R7", 1, 0, 8, 0, 0, 0, 0, 0);
        // R12 simultaneous writes, main port wins
        step("R12", 1, 1, 0, 0, 'hF, 1, 0, 1);
        step("R12", 1, 0, 0, 0, 0, 0, 0, 0);
        step("R12", 1, 1, 0, 1, 'hF, 1, 0, 0);
        step("R12", 1, 0, 0, 0, 0, 0, 0, 0);
        // back-to-back toggles
        for (int i = 0; i < 6; i++) begin
            step("R5", 1, 1, 0, i % 2, 'hF, 0, 0, 0);
        end
        step("R2", 1, 0, 0, 0, 0, 0, 0, 0);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule